// File: doc/BRIEF.md
# Tuner Synthesizer Status Read Slave

This block is the read side of a two-wire serial control port for a tuner frequency synthesizer. It watches the clock and data lines of an I2C bus, recognises its own 7-bit slave address with the read direction bit set, and acknowledges it. It then returns a status byte that carries four things: a sticky power-on flag, the loop-lock indication, the levels of three digital I/O ports and a 3-bit converter result. The port that selects the address gives four settings. Three of them fix the two low address bits. The fourth accepts either value of those bits.

The bus lines are brought into the fast system clock through two-stage synchronizers. Every SCL edge, START and STOP is found by comparing each sampled line with its value one clock earlier. The block drives SDA only as an open-drain pull-down enable. Each status byte is captured at the moment its first bit goes out. While the master acknowledges, the block keeps sending fresh status bytes. When the master does not acknowledge, the block lets go of SDA and clears the power-on flag. A STOP or a repeated START ends any transfer at once. The block has no data stream with back-pressure: the serial protocol sets the pace, so all pins are plain control and status signals.

Top module: `tuner_status_slave`

## Requirements
- R1: A received address byte is acknowledged (SDA pulled low during the ninth SCL clock) when all three of these hold. Its upper five bits, sent first, are 1,1,0,0,0. Its last bit (R/W) is 1. Its two remaining address bits {MA1,MA0} equal `asel_i`, or `asel_i` is 2'b01, which accepts any MA value.
- R2: An address byte that fails R1 (wrong prefix, wrong MA bits, or R/W = 0) gets no acknowledge, and SDA stays released until the next START.
- R3: The status byte goes out MSB first as {POR, lock_i, port_lvl_i[2], port_lvl_i[1], port_lvl_i[0], adc_i[2], adc_i[1], adc_i[0]}. A released SDA reads as 1.
- R4: The SDA pull-down changes only while SCL is low, so the data is stable throughout every SCL high phase.
- R5: When the master acknowledges (drives SDA low in the ninth clock after a status byte), another status byte follows, built from the input values at its start.
- R6: Each status byte is captured as its first bit is driven. Input changes during the byte do not alter the bits that are sent.
- R7: POR reads 1 after reset. It is cleared only when the master does not acknowledge a status byte, and SDA is released at that point. A transfer cut short by STOP leaves POR at 1.
- R8: A STOP or a repeated START at any point releases SDA and abandons the transfer. After a repeated START the next byte is taken as a new address.
- R9: While reset is active, and after it ends, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset (power-on) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| asel_i | input | 2 | Address select: MA1,MA0 value, or 2'b01 to accept any |
| lock_i | input | 1 | Loop locked indication |
| port_lvl_i | input | 3 | Digital port levels, MSB first in status byte |
| adc_i | input | 3 | Converter result code |
| sda_pull_o | output | 1 | 1 = pull SDA low |

## Verification
A table of addresses is run through all four select settings. It covers exact matches, a wrong MA value under a fixed setting, the accept-any setting with several MA values, a wrong prefix and a write bit, so that an error in each part of the address compare shows up as a missing or extra acknowledge. The status byte contents vary from row to row, so a swapped or misplaced field shows up. Directed sequences then cover the following:
- a two-byte read whose inputs change mid-byte, which separates capture at byte start from live shifting;
- an ACK followed by a NACK, which checks that POR stays set and is then cleared;
- a STOP abort, which checks that POR is not cleared by an aborted transfer;
- a repeated START, after which a wrong address must not be acknowledged.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int ADDR_BITS = 8;
  localparam logic [1:0] SEL_ANY = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKW,
    ST_LOAD,
    ST_TX,
    ST_MACK
  } tsr_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '1;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tsr_events.sv
module tsr_events
  import tsr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt.start = scl_s & scl_q & sda_q & ~sda_s;
    evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
    evt.rise  = scl_s & ~scl_q;
    evt.fall  = ~scl_s & scl_q;
  end
endmodule

// File: rtl/tsr_engine.sv
module tsr_engine
  import tsr_pkg::*;
#(
  parameter int         PORT_W      = 3,
  parameter int         ADC_W       = 3,
  parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bus_evt_t             evt,
  input  logic                 sda_s,
  input  logic [1:0]           asel,
  input  logic                 lock,
  input  logic [PORT_W-1:0]    port_lvl,
  input  logic [ADC_W-1:0]     adc,
  output logic                 pull,
  output logic                 por,
  output tsr_state_e           state
);
  localparam int STAT_W = 2 + PORT_W + ADC_W;
  localparam int MAX_W  = (STAT_W > ADDR_BITS) ? STAT_W : ADDR_BITS;
  localparam int CNT_W  = $clog2(MAX_W);

  logic [CNT_W-1:0]     cnt;
  logic [ADDR_BITS-1:0] rx;
  logic [ADDR_BITS-1:0] rx_nxt;
  logic [STAT_W-1:0]    shreg;
  logic [STAT_W-1:0]    snap;

  assign rx_nxt = {rx[ADDR_BITS-2:0], sda_s};
  assign snap   = {por, lock, port_lvl, adc};

  function automatic logic addr_hit(input logic [ADDR_BITS-1:0] b,
                                    input logic [1:0] sel);
    return (b[7:3] == ADDR_PREFIX) && b[0] &&
           ((sel == SEL_ANY) || (b[2:1] == sel));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rx    <= '0;
      shreg <= '0;
      pull  <= 1'b0;
      por   <= 1'b1;
    end else if (evt.start) begin
      state <= ST_ADDR;
      cnt   <= '0;
      pull  <= 1'b0;
    end else if (evt.stop) begin
      state <= ST_IDLE;
      pull  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (evt.rise) begin
          rx <= rx_nxt;
          if (cnt == CNT_W'(ADDR_BITS-1)) begin
            cnt   <= '0;
            state <= addr_hit(rx_nxt, asel) ? ST_ACKW : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACKW: if (evt.fall) begin
          pull  <= 1'b1;
          state <= ST_LOAD;
        end
        ST_LOAD: if (evt.fall) begin
          shreg <= snap;
          pull  <= ~snap[STAT_W-1];
          cnt   <= '0;
          state <= ST_TX;
        end
        ST_TX: if (evt.fall) begin
          if (cnt == CNT_W'(STAT_W-1)) begin
            pull  <= 1'b0;
            state <= ST_MACK;
          end else begin
            shreg <= {shreg[STAT_W-2:0], 1'b0};
            pull  <= ~shreg[STAT_W-2];
            cnt   <= cnt + 1'b1;
          end
        end
        ST_MACK: if (evt.rise) begin
          if (!sda_s) begin
            state <= ST_LOAD;
          end else begin
            por   <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tuner_status_slave.sv
module tuner_status_slave
  import tsr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         PORT_W      = 3,
  parameter int         ADC_W       = 3,
  parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        asel_i,
  input  logic              lock_i,
  input  logic [PORT_W-1:0] port_lvl_i,
  input  logic [ADC_W-1:0]  adc_i,
  output logic              sda_pull_o
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  bus_evt_t   evt;
  logic       por_flag;
  tsr_state_e eng_state;

  tsr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  tsr_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
  );

  tsr_engine #(
    .PORT_W(PORT_W), .ADC_W(ADC_W), .ADDR_PREFIX(ADDR_PREFIX)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sda_s(sda_s), .asel(asel_i),
    .lock(lock_i), .port_lvl(port_lvl_i), .adc(adc_i),
    .pull(sda_pull_o), .por(por_flag), .state(eng_state)
  );
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker
  import tsr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       pull,
  input logic       por,
  input bus_evt_t   evt,
  input tsr_state_e state
);
  // R4: pull-down moves only while SCL is low, apart from START/STOP release
  p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pull) && !$past(evt.start || evt.stop)) |-> !scl_s);

  // R8: a STOP releases the line on the next cycle
  p_release_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> !pull);

  // R7: once cleared, POR never returns without reset
  p_por_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !por |=> !por);

  // R2: no pull-down while the engine is idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !pull);

  // R1: leaving the ack-wait state always drives the acknowledge
  p_ack_driven_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_ACKW && state == ST_LOAD) |-> pull);
endmodule

bind tuner_status_slave tsr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .pull(sda_pull_o),
  .por(por_flag), .evt(evt), .state(eng_state)
);

// File: tb/tuner_status_slave_test.sv
`timescale 1ns/1ps
module tuner_status_slave_test;
  localparam int Q = 8;
  localparam int NV = 10;
  // {asel, addr7, rw, lock, ports, adc, expect_ack}
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 7'b1100000, 1'b1, 1'b1, 3'b001, 3'b100, 1'b1},
    {2'b00, 7'b1100001, 1'b1, 1'b0, 3'b111, 3'b000, 1'b0},
    {2'b10, 7'b1100010, 1'b1, 1'b0, 3'b110, 3'b010, 1'b1},
    {2'b11, 7'b1100011, 1'b1, 1'b1, 3'b010, 3'b111, 1'b1},
    {2'b11, 7'b1100010, 1'b1, 1'b1, 3'b000, 3'b001, 1'b0},
    {2'b01, 7'b1100011, 1'b1, 1'b0, 3'b011, 3'b101, 1'b1},
    {2'b01, 7'b1100000, 1'b1, 1'b1, 3'b100, 3'b000, 1'b1},
    {2'b00, 7'b1100000, 1'b0, 1'b1, 3'b000, 3'b000, 1'b0},
    {2'b01, 7'b1100100, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0},
    {2'b10, 7'b0100010, 1'b1, 1'b1, 3'b101, 3'b010, 1'b0}
  };

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic [1:0] asel = 0;
  logic lock = 0;
  logic [2:0] ports = 0, adc = 0;
  logic pull;
  wire  sda_line = sda_m & ~pull;
  int   checks = 0, fails = 0, r4_bad = 0;

  always #2.5 clk = ~clk;

  tuner_status_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .asel_i(asel), .lock_i(lock), .port_lvl_i(ports), .adc_i(adc),
    .sda_pull_o(pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 0; sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask

  task automatic read_bit(output logic b);
    logic s1;
    sda_m = 1; tick(Q); scl = 1; tick(2); s1 = sda_line;
    tick(2*Q-2); b = sda_line;
    if (s1 !== b) r4_bad++;
    scl = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic read_bits(input int n, inout logic [7:0] v);
    logic b;
    for (int i = 0; i < n; i++) begin
      read_bit(b);
      v = {v[6:0], b};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] got;
    logic [17:0] v;
    logic [7:0] exp_b;

    // R9: released during and after reset
    tick(10);
    check(pull == 1'b0, "R9", "pull in reset", pull, 0);
    rst_n = 1; tick(5);
    check(pull == 1'b0, "R9", "pull after reset", pull, 0);

    // R8 / R7: STOP mid-byte aborts, POR stays set
    asel = 2'b00; lock = 1; ports = 3'b101; adc = 3'b011;
    bus_start(); send_byte({7'b1100000, 1'b1}); read_bit(ack);
    check(ack == 1'b0, "R1", "ack on match", ack, 0);
    got = 0; read_bits(2, got);
    check(got[1:0] == 2'b11, "R3", "POR,lock bits", got[1:0], 3);
    bus_stop(); tick(4);
    check(pull == 1'b0, "R8", "released after stop", pull, 0);

    // R5 / R6: two bytes, inputs change mid-byte
    bus_start(); send_byte({7'b1100000, 1'b1}); read_bit(ack);
    check(ack == 1'b0, "R1", "ack second read", ack, 0);
    got = 0; read_bits(4, got);
    lock = 0; ports = 3'b010; adc = 3'b110;
    read_bits(4, got);
    check(got == 8'b11101011, "R6", "byte latched at start", got, 8'hEB);
    send_bit(1'b0);
    got = 0; read_bits(8, got);
    check(got == 8'b10010110, "R5", "second byte fresh, POR kept", got, 8'h96);
    send_bit(1'b1); tick(4);
    check(pull == 1'b0, "R7", "released after nack", pull, 0);
    bus_stop();

    // R7: POR now cleared
    bus_start(); send_byte({7'b1100000, 1'b1}); read_bit(ack);
    got = 0; read_bits(8, got);
    check(got == 8'b00010110, "R7", "POR cleared after nack", got, 8'h16);
    send_bit(1'b1); bus_stop();

    // R8: repeated START restarts address phase
    lock = 1;
    bus_start(); send_byte({7'b1100000, 1'b1}); read_bit(ack);
    got = 0; read_bits(1, got);
    bus_start(); send_byte({7'b1100001, 1'b1}); read_bit(ack);
    check(ack == 1'b1, "R8", "new address after rep start", ack, 1);
    bus_stop();

    // R1 / R2 / R3: vector table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      asel = v[17:16]; lock = v[7]; ports = v[6:4]; adc = v[3:1];
      bus_start(); send_byte({v[15:9], v[8]}); read_bit(ack);
      check(ack == ~v[0], v[0] ? "R1" : "R2", $sformatf("ack vec %0d", i), ack, ~v[0]);
      if (v[0]) begin
        exp_b = {1'b0, v[7], v[6:4], v[3:1]};
        got = 0; read_bits(8, got);
        check(got == exp_b, "R3", $sformatf("status vec %0d", i), got, exp_b);
        send_bit(1'b1);
      end else begin
        tick(4);
        check(pull == 1'b0, "R2", $sformatf("released vec %0d", i), pull, 0);
      end
      bus_stop();
    end

    // R4: data stable across every sampled high phase
    check(r4_bad == 0, "R4", "SDA changed while SCL high", r4_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule